// File: doc/BRIEF.md
# Circular Return-Address Stack

This block holds subroutine return addresses for a small 8-bit controller whose program counter is `AW` bits wide (12 by default). When a call, or an interrupt that branches, executes, the surrounding sequencer raises a push strobe and presents the program counter value to be saved. When a return-with-literal executes, it raises a pop strobe and uses the address already shown on the top-of-stack output as the target. The number of levels is a parameter from 1 to 8, with 2 as the default.

The storage is a ring of `DEPTH` address registers with a hidden write pointer. The stack is not part of program or data memory, and software cannot read or write its pointer. If more pushes arrive than there are levels, the ring wraps and overwrites the oldest entry. If more pops arrive than there were pushes, the pointer wraps backwards. Neither case raises a flag. The external reset is applied asynchronously and released through a two-stage synchronizer. Reset clears the pointer and leaves the stored addresses unchanged.

Top module: `ret_ring_stack`

## Requirements
- R1: While reset is active the pointer is zero. The stored addresses are not cleared. After reset, and before any strobe, the output shows the slot with the highest index (`DEPTH-1`). A pop then shows slot `DEPTH-2` (wrapping).
- R2: A push writes `push_addr_i` into the slot at the pointer and advances the pointer, wrapping from `DEPTH-1` to 0. From the next cycle, `top_addr_o` equals the pushed address.
- R3: A pop with no push moves the pointer back by one. From the next cycle, `top_addr_o` shows the address pushed before the one just removed (last-in, first-out for up to `DEPTH` entries).
- R4: After `DEPTH` pushes, the next push overwrites the oldest entry. Popping then cycles through the entries still held, with no error indication.
- R5: A pop on an empty stack moves the pointer from 0 to `DEPTH-1` and shows whatever that wrapped slot holds. Repeated pops keep cycling around the ring.
- R6: When push and pop are asserted in the same cycle, only the push takes effect.
- R7: In a cycle with neither strobe, the pointer and `top_addr_o` keep their values.
- R8: Strobes are ignored while `rst_n` is low and on the first two rising clock edges after `rst_n` rises. The third edge is the first that acts on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released after two clock edges |
| push_i | input | 1 | Save `push_addr_i` and advance the pointer |
| pop_i | input | 1 | Discard the top entry and step the pointer back |
| push_addr_i | input | AW | Return address to save |
| top_addr_o | output | AW | Address held at the current top of the ring |

## Verification
The hardest situations to reach from the ports are the pointer value right after reset and the two edges on which strobes are ignored while reset is released. The ring is symmetric, so a pointer that is off by one cannot be seen with fresh data. The stimulus therefore fills both slots with known addresses, applies reset while a push of a marker value is held, and raises a single pop only on the second edge after release. Because storage survives reset, a correct pointer shows the previously stored slot-1 address and then, after one pop, the slot-0 address. A wrong pointer, a single-stage synchronizer or a write during reset shows a different value.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

  // Operation selected in a cycle; push wins over pop.
  typedef enum logic [1:0] {
    RRS_IDLE = 2'd0,
    RRS_PUSH = 2'd1,
    RRS_POP  = 2'd2
  } rrs_op_e;

  function automatic rrs_op_e rrs_decode(input logic push, input logic pop);
    if (push)     return RRS_PUSH;
    else if (pop) return RRS_POP;
    else          return RRS_IDLE;
  endfunction

endpackage

// File: rtl/rrs_rst_sync.sv
module rrs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/rrs_ptr.sv
module rrs_ptr #(
  parameter int DEPTH = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          wr_en_o,
  output logic [PW-1:0] wr_ptr_o,
  output logic [PW-1:0] top_idx_o
);
  import rrs_pkg::*;

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  rrs_op_e        op;
  logic [PW-1:0]  ptr_q;
  logic [PW-1:0]  ptr_d;
  logic [PW-1:0]  ptr_inc;
  logic [PW-1:0]  ptr_dec;
  logic           ptr_en;

  always_comb begin
    op      = rrs_decode(push_i, pop_i);
    ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + PW'(1);
    ptr_dec = (ptr_q == '0) ? LAST : ptr_q - PW'(1);
    ptr_en  = 1'b0;
    ptr_d   = ptr_q;
    unique case (op)
      RRS_PUSH: begin
        ptr_en = 1'b1;
        ptr_d  = ptr_inc;
      end
      RRS_POP: begin
        ptr_en = 1'b1;
        ptr_d  = ptr_dec;
      end
      default: begin
        ptr_en = 1'b0;
        ptr_d  = ptr_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  // The storage has no reset, so its write is gated by reset here.
  assign wr_en_o   = (op == RRS_PUSH) && rst_n;
  assign wr_ptr_o  = ptr_q;
  assign top_idx_o = ptr_dec;

endmodule

// File: rtl/rrs_bank.sv
module rrs_bank #(
  parameter int DEPTH = 2,
  parameter int AW    = 12,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en_i,
  input  logic [PW-1:0] wr_idx_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic [PW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_data_o
);

  logic [AW-1:0] slot_flat [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : gen_slot
    logic          load;
    logic [AW-1:0] q;

    assign load = wr_en_i && (wr_idx_i == PW'(gi));

    always_ff @(posedge clk) begin
      if (load) begin
        q <= wr_data_i;
      end
    end

    assign slot_flat[gi] = q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx_i == PW'(i)) begin
        rd_data_o = slot_flat[i];
      end
    end
  end

endmodule

// File: rtl/ret_ring_stack.sv
module ret_ring_stack #(
  parameter int DEPTH = 2,
  parameter int AW    = 12,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_addr_i,
  output logic [AW-1:0] top_addr_o
);

  logic          rst_sync_n;
  logic          wr_en;
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] top_idx;

  rrs_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rrs_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .wr_en_o   (wr_en),
    .wr_ptr_o  (wr_ptr),
    .top_idx_o (top_idx)
  );

  rrs_bank #(.DEPTH(DEPTH), .AW(AW)) u_bank (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_ptr),
    .wr_data_i (push_addr_i),
    .rd_idx_i  (top_idx),
    .rd_data_o (top_addr_o)
  );

endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
  parameter int DEPTH = 2,
  parameter int AW    = 12,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          push_i,
  input logic          pop_i,
  input logic [AW-1:0] push_addr_i,
  input logic [AW-1:0] top_addr_o,
  input logic [PW-1:0] wr_ptr
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  AST_RESET_PTR_ZERO: assert property (@(posedge clk)
    !rst_sync_n |-> wr_ptr == '0); // R1

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_ptr <= LAST); // R2

  AST_PUSH_SHOWS_ADDR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    push_i |=> top_addr_o == $past(push_addr_i)); // R2

  AST_PUSH_WRAPS_FWD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (push_i && wr_ptr == LAST) |=> wr_ptr == '0); // R4

  AST_POP_WRAPS_BACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pop_i && !push_i && wr_ptr == '0) |=> wr_ptr == LAST); // R5

  AST_POP_STEPS_BACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pop_i && !push_i && wr_ptr != '0) |=> wr_ptr == $past(wr_ptr) - PW'(1)); // R3

  AST_PUSH_OVER_POP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (push_i && pop_i) |=> top_addr_o == $past(push_addr_i)); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!push_i && !pop_i) |=> ($stable(wr_ptr) && $stable(top_addr_o))); // R7

endmodule

bind ret_ring_stack rrs_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .push_addr_i (push_addr_i),
  .top_addr_o  (top_addr_o),
  .wr_ptr      (wr_ptr)
);

// File: tb/ret_ring_stack_tb.sv
module ret_ring_stack_tb;

  localparam int DEPTH = 2;
  localparam int AW    = 12;

  logic          clk;
  logic          rst_n;
  logic          push_i;
  logic          pop_i;
  logic [AW-1:0] push_addr_i;
  logic [AW-1:0] top_addr_o;

  int checks;
  int fails;
  bit done;

  // Scoreboard queues
  logic [AW-1:0] exp_q [$];
  string         tag_q [$];

  // Behavioural model of the requirements
  logic [AW-1:0] m_slot  [DEPTH];
  bit            m_known [DEPTH];
  int            m_ptr;

  ret_ring_stack #(.DEPTH(DEPTH), .AW(AW)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .push_addr_i (push_addr_i),
    .top_addr_o  (top_addr_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int top_of(int p);
    return (p + DEPTH - 1) % DEPTH;
  endfunction

  task automatic expect_top(string tag);
    int t;
    t = top_of(m_ptr);
    if (m_known[t]) begin
      exp_q.push_back(m_slot[t]);
      tag_q.push_back(tag);
    end
  endtask

  // Driver: one cycle of strobes, model update, expected value enqueued
  task automatic step(bit psh, bit pp, logic [AW-1:0] addr, string tag);
    @(negedge clk);
    push_i      = psh;
    pop_i       = pp;
    push_addr_i = addr;
    @(posedge clk);
    if (psh) begin
      m_slot[m_ptr]  = addr;
      m_known[m_ptr] = 1'b1;
      m_ptr          = (m_ptr + 1) % DEPTH;
    end else if (pp) begin
      m_ptr = (m_ptr + DEPTH - 1) % DEPTH;
    end
    expect_top(tag);
  endtask

  // Reset with a marker push held during reset and one pop on the
  // second edge after release; both must be ignored (R8).
  task automatic reset_with_noise();
    @(negedge clk);
    rst_n       = 1'b0;
    push_i      = 1'b1;
    pop_i       = 1'b0;
    push_addr_i = 12'hBAD;
    repeat (2) @(negedge clk);
    push_i = 1'b0;
    rst_n  = 1'b1;
    @(posedge clk);           // first edge after release
    @(negedge clk);
    pop_i = 1'b1;
    @(posedge clk);           // second edge after release
    @(negedge clk);
    pop_i = 1'b0;
    m_ptr = 0;
  endtask

  // Monitor: compares one expected value per cycle away from the edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [AW-1:0] e;
        string         tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        checks++;
        if (top_addr_o !== e) begin
          fails++;
          $display("FAIL %s: top_addr_o=%h expected=%h", tg, top_addr_o, e);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    checks      = 0;
    fails       = 0;
    done        = 1'b0;
    rst_n       = 1'b0;
    push_i      = 1'b0;
    pop_i       = 1'b0;
    push_addr_i = '0;
    m_ptr       = 0;
    for (int i = 0; i < DEPTH; i++) m_known[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: pushes show on top the next cycle
    step(1, 0, 12'h111, "R2 push first");
    step(1, 0, 12'h222, "R2 push second");

    // R1 + R8: reset keeps storage, clears pointer, ignores strobes
    reset_with_noise();
    expect_top("R1 top after reset is slot DEPTH-1");
    step(0, 0, 12'h000, "R8 strobes during reset release ignored");
    step(0, 1, 12'h000, "R1 pop after reset shows slot 0");

    // R7: idle cycles hold top
    step(0, 0, 12'h3C3, "R7 idle hold");
    step(0, 0, 12'hFFF, "R7 idle hold with changing addr");

    // R3: LIFO order
    step(1, 0, 12'hA01, "R2 push A01");
    step(1, 0, 12'hA02, "R2 push A02");
    step(0, 1, 12'h000, "R3 pop shows A01");

    // R4: overflow overwrites oldest
    step(1, 0, 12'hB01, "R2 push B01");
    step(1, 0, 12'hB02, "R4 push B02");
    step(1, 0, 12'hB03, "R4 push B03 overwrites B01");
    step(0, 1, 12'h000, "R4 pop shows B02");
    step(0, 1, 12'h000, "R4 pop wraps to B03");

    // R5: pops past empty keep cycling
    step(0, 1, 12'h000, "R5 pop on empty wraps");
    step(0, 1, 12'h000, "R5 second pop on empty wraps");

    // R6: push wins over pop
    step(1, 1, 12'hC5A, "R6 push over pop");
    step(1, 1, 12'h5AC, "R6 push over pop again");
    step(0, 1, 12'h000, "R6 pop after simultaneous strobes");
    step(0, 0, 12'h000, "R7 idle after pop");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule